// File: doc/BRIEF.md
# Dual-View Interrupt Mask Bank

This block holds the mask flags for 52 maskable interrupt sources, packed into four 16-bit words on a small memory-mapped bus. The words sit at byte offsets 0x0, 0x2, 0x4 and 0x6, selected here by a word index (offset = 2 × index). A set flag (1) holds its source back, and the request stays pending. A clear flag (0) lets the request pass. Every flag comes out of reset set. Source `i` lives in word `i/16`, bit `i%16`. The first three words are fully populated. The last word carries only bits 0 to 3, and its other bits always read as 1.

Each flag has a second view: the mask field of that source's own control register, reached through the alias port (`src_*`). Both views address one flop, so a write through either is seen by both. Besides word and byte writes, a separate single-bit port can set, clear or load one flag in one cycle without touching the others. Raw requests come in on `irq_raw`. `irq_gated` gives the masked requests, registered, to a priority resolver further on.

All pins are plain control pins. A bus access is a one-cycle pulse on `bus_req` with no back-pressure. Read data returns with `bus_rvalid` on the following cycle, and it cannot be stalled.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset every word reads 0xFFFF, `irq_gated` is all zero and `bus_rvalid` is 0.
- R2: A write with `bus_be`=2'b11 replaces all implemented bits of the selected word.
- R3: `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8 for writes. On reads, a lane that is not enabled returns zeros.
- R4: `bit_op` 2'd1 sets, 2'd2 clears and 2'd3 loads `bit_val` into flag `bit_sel` (word = `bit_sel[5:4]`, bit = `bit_sel[3:0]`). No other flag changes. 2'd0 does nothing.
- R5: An alias write (`src_we`) sets flag `src_idx` to `src_val`, and later bank reads show it. `src_mask` shows flag `src_idx` combinationally, including changes made by bank writes.
- R6: When an alias write and a bank or bit write hit the same flag in one cycle, the alias value is kept. The other bits of the bank write still land.
- R7: When a bit operation and a bank write hit the same flag in one cycle, the bit operation's result is kept.
- R8: Bits 15:4 of word 3 always read 1. Writes to them are ignored on every path, including alias indices 52 to 63.
- R9: `irq_gated` equals the previous cycle's `irq_raw & ~mask`.
- R10: `bus_rvalid` rises exactly one cycle after a read request. `bus_rdata` then holds the word's contents as they stood in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Word index (byte offset / 2) |
| bus_be | input | 2 | Byte lane enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, lane-masked |
| bus_rvalid | output | 1 | Read data valid |
| bit_op | input | 2 | Single-bit opcode |
| bit_sel | input | 6 | Flag addressed by bit operation |
| bit_val | input | 1 | Value for load opcode |
| src_we | input | 1 | Alias write strobe |
| src_idx | input | 6 | Source number for alias view |
| src_val | input | 1 | Alias write value |
| src_mask | output | 1 | Flag of source `src_idx` |
| irq_raw | input | 52 | Raw requests |
| irq_gated | output | 52 | Masked, registered requests |

## Verification
The assertions check four things on every cycle: the gating relation with its one-cycle delay, the read-valid timing, zeroing of a disabled upper lane, and that an alias write lands on its flag. A further assertion checks that the flags stay stable when no write path is active. The bench scenarios are needed for the rest: the three-way write priority, the fixed-one bits of the last word under all write paths, and byte-lane merging. A reference model of the flags checks each of these through bank reads and the alias readback.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  typedef enum logic [1:0] {
    BOP_NONE  = 2'd0,
    BOP_SET   = 2'd1,
    BOP_CLR   = 2'd2,
    BOP_WRITE = 2'd3
  } bitop_e;
endpackage

// File: rtl/irq_mask_word.sv
module irq_mask_word
  import irq_mask_pkg::*;
#(
  parameter int W    = 16,
  parameter int IMPL = 16,
  localparam int PW  = $clog2(W),
  localparam int NB  = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [NB-1:0] be,
  input  logic [W-1:0]  wdata,
  input  logic          bit_hit,
  input  bitop_e        bop,
  input  logic [PW-1:0] bit_pos,
  input  logic          bit_val,
  input  logic          al_hit,
  input  logic [PW-1:0] al_pos,
  input  logic          al_val,
  output logic [W-1:0]  q
);
  localparam logic [W:0]   ONE_EXT   = (W+1)'(1) << IMPL;
  localparam logic [W-1:0] IMPL_MASK = W'(ONE_EXT - (W+1)'(1));

  logic [W-1:0] st, nxt;

  // Write priority: bank lanes, then bit operation, then alias view.
  always_comb begin
    nxt = st;
    if (bus_wr) begin
      for (int b = 0; b < NB; b++) begin
        if (be[b]) nxt[b*8 +: 8] = wdata[b*8 +: 8];
      end
    end
    if (bit_hit) begin
      case (bop)
        BOP_SET:   nxt[bit_pos] = 1'b1;
        BOP_CLR:   nxt[bit_pos] = 1'b0;
        BOP_WRITE: nxt[bit_pos] = bit_val;
        default:   ;
      endcase
    end
    if (al_hit) nxt[al_pos] = al_val;
    nxt = nxt | ~IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '1;
    else        st <= nxt;
  end

  assign q = st;
endmodule

// File: rtl/irq_mask_rdport.sv
module irq_mask_rdport #(
  parameter int W  = 16,
  parameter int NW = 4,
  localparam int IW = $clog2(NW),
  localparam int NB = W / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic [IW-1:0]   widx,
  input  logic [NB-1:0]   be,
  input  logic [NW*W-1:0] words,
  output logic [W-1:0]    rdata,
  output logic            rvalid
);
  logic [W-1:0] sel, lane;

  always_comb begin
    sel = '0;
    for (int w = 0; w < NW; w++) begin
      if (widx == IW'(w)) sel = words[w*W +: W];
    end
    for (int b = 0; b < NB; b++) begin
      lane[b*8 +: 8] = be[b] ? sel[b*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= lane;
    end
  end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int N = 52
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] mask,
  output logic [N-1:0] gated
);
  always_ff @(posedge clk) begin
    if (!rst_n) gated <= '0;
    else        gated <= raw & ~mask;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_mask_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 16,
  parameter int LAST_IMPL = 4,
  localparam int NSRC   = (NUM_WORDS - 1) * WORD_W + LAST_IMPL,
  localparam int TOTAL  = NUM_WORDS * WORD_W,
  localparam int WIDX_W = $clog2(NUM_WORDS),
  localparam int PW     = $clog2(WORD_W),
  localparam int SEL_W  = WIDX_W + PW,
  localparam int LANES  = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [WIDX_W-1:0] bus_word,
  input  logic [LANES-1:0]  bus_be,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [1:0]        bit_op,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              bit_val,
  input  logic              src_we,
  input  logic [SEL_W-1:0]  src_idx,
  input  logic              src_val,
  output logic              src_mask,
  input  logic [NSRC-1:0]   irq_raw,
  output logic [NSRC-1:0]   irq_gated
);
  logic [TOTAL-1:0] mask_all;
  bitop_e           bop;

  assign bop = bitop_e'(bit_op);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int IMPL = (w == NUM_WORDS - 1) ? LAST_IMPL : WORD_W;
    logic wr_hit, b_hit, a_hit;
    assign wr_hit = bus_req && bus_we && (bus_word == WIDX_W'(w));
    assign b_hit  = (bop != BOP_NONE) && (bit_sel[SEL_W-1:PW] == WIDX_W'(w));
    assign a_hit  = src_we && (src_idx[SEL_W-1:PW] == WIDX_W'(w));

    irq_mask_word #(.W(WORD_W), .IMPL(IMPL)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_wr  (wr_hit),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .bit_hit (b_hit),
      .bop     (bop),
      .bit_pos (bit_sel[PW-1:0]),
      .bit_val (bit_val),
      .al_hit  (a_hit),
      .al_pos  (src_idx[PW-1:0]),
      .al_val  (src_val),
      .q       (mask_all[w*WORD_W +: WORD_W])
    );
  end

  assign src_mask = mask_all[src_idx];

  irq_mask_rdport #(.W(WORD_W), .NW(NUM_WORDS)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_req && !bus_we),
    .widx   (bus_word),
    .be     (bus_be),
    .words  (mask_all),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  irq_mask_gate #(.N(NSRC)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (irq_raw),
    .mask  (mask_all[NSRC-1:0]),
    .gated (irq_gated)
  );
endmodule

// File: rtl/irq_mask_bank_chk.sv
module irq_mask_bank_chk #(
  parameter int NSRC   = 52,
  parameter int TOTAL  = 64,
  parameter int SEL_W  = 6,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [1:0]        bus_be,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [1:0]        bit_op,
  input logic              src_we,
  input logic [SEL_W-1:0]  src_idx,
  input logic              src_val,
  input logic [NSRC-1:0]   irq_raw,
  input logic [NSRC-1:0]   irq_gated,
  input logic [TOTAL-1:0]  mask_all
);
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_gated == $past(irq_raw & ~mask_all[NSRC-1:0]));

  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid == $past(bus_req && !bus_we));

  p_hi_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && !$past(bus_be[1])) |-> (bus_rdata[WORD_W-1 -: 8] == 8'h00));

  p_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_we) && ($past(src_idx) < SEL_W'(NSRC)))
      |-> (mask_all[$past(src_idx)] == $past(src_val)));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bus_req && bus_we) && ($past(bit_op) == 2'd0) && !$past(src_we))
      |-> $stable(mask_all));
endmodule

bind irq_mask_bank irq_mask_bank_chk #(
  .NSRC(NSRC), .TOTAL(TOTAL), .SEL_W(SEL_W), .WORD_W(WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_be     (bus_be),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .bit_op     (bit_op),
  .src_we     (src_we),
  .src_idx    (src_idx),
  .src_val    (src_val),
  .irq_raw    (irq_raw),
  .irq_gated  (irq_gated),
  .mask_all   (mask_all)
);

// File: tb/sim_irq_mask_bank.sv
`timescale 1ns/1ps
module sim_irq_mask_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 0, bus_we = 0;
  logic [1:0]  bus_word = 0, bus_be = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  bit_op = 0;
  logic [5:0]  bit_sel = 0;
  logic        bit_val = 0;
  logic        src_we = 0;
  logic [5:0]  src_idx = 0;
  logic        src_val = 0;
  logic        src_mask;
  logic [51:0] irq_raw = 0;
  logic [51:0] irq_gated;

  always #4 clk = ~clk;

  irq_mask_bank u0 (.*);

  int          n_chk = 0, n_bad = 0;
  logic [63:0] m = '1;
  logic        exp_rv = 0;
  logic [15:0] exp_rd = 0;
  logic [51:0] exp_g = 0;
  string       pend = "R10";

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] upd(input logic [63:0] cur, input logic req, we,
      input logic [1:0] wd_i, be, input logic [15:0] wd, input logic [1:0] op,
      input logic [5:0] sel, input logic bv, swe, input logic [5:0] sidx, input logic sv);
    logic [63:0] n = cur;
    if (req && we) begin
      if (be[0]) n[wd_i*16 +: 8] = wd[7:0];
      if (be[1]) n[wd_i*16 + 8 +: 8] = wd[15:8];
    end
    case (op)
      2'd1: n[sel] = 1'b1;
      2'd2: n[sel] = 1'b0;
      2'd3: n[sel] = bv;
      default: ;
    endcase
    if (swe) n[sidx] = sv;
    n[63:52] = '1;
    return n;
  endfunction

  task automatic step(input string lbl, input logic req, we, input logic [1:0] wi, be,
      input logic [15:0] wd, input logic [1:0] op, input logic [5:0] sel, input logic bv,
      input logic swe, input logic [5:0] sidx, input logic sv, input logic [51:0] raw);
    logic [15:0] w;
    @(negedge clk);
    chk("R10 rvalid", 64'(bus_rvalid), 64'(exp_rv));
    if (exp_rv) chk(pend, 64'(bus_rdata), 64'(exp_rd));
    chk("R9 gated", 64'(irq_gated), 64'(exp_g));
    bus_req = req; bus_we = we; bus_word = wi; bus_be = be; bus_wdata = wd;
    bit_op = op; bit_sel = sel; bit_val = bv;
    src_we = swe; src_idx = sidx; src_val = sv; irq_raw = raw;
    #1;
    chk("R5 src_mask", 64'(src_mask), 64'(m[sidx]));
    w = m[wi*16 +: 16];
    exp_rv = req && !we;
    exp_rd = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
    exp_g  = raw & ~m[51:0];
    pend   = lbl;
    m = upd(m, req, we, wi, be, wd, op, sel, bv, swe, sidx, sv);
  endtask

  task automatic rd(input string lbl, input logic [1:0] wi, input logic [1:0] be);
    step(lbl, 1, 0, wi, be, 0, 0, 0, 0, 0, 0, 0, irq_raw);
  endtask

  task automatic idle();
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, irq_raw);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 rvalid", 64'(bus_rvalid), 0);
    chk("R1 gated", 64'(irq_gated), 0);
    rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '1);
    for (int k = 0; k < 4; k++) rd("R1 reset word", 2'(k), 2'b11);
    // R2 full-word write
    step("R2", 1, 1, 1, 2'b11, 16'h1234, 0, 0, 0, 0, 0, 0, '1);
    rd("R2 word write", 1, 2'b11);
    // R3 byte lanes
    step("R3", 1, 1, 0, 2'b01, 16'hAB00, 0, 0, 0, 0, 0, 0, '1);
    rd("R3 upper lane only", 0, 2'b10);
    rd("R3 lower lane only", 0, 2'b01);
    // R4 bit operations
    step("R4", 0, 0, 0, 0, 0, 2'd2, 6'd37, 0, 0, 0, 0, '1);
    step("R4", 0, 0, 0, 0, 0, 2'd1, 6'd0, 0, 0, 0, 0, '1);
    step("R4", 0, 0, 0, 0, 0, 2'd3, 6'd38, 0, 0, 0, 0, '1);
    step("R4", 0, 0, 0, 0, 0, 2'd0, 6'd39, 0, 0, 0, 0, '1);
    rd("R4 bit ops word2", 2, 2'b11);
    rd("R4 bit ops word0", 0, 2'b11);
    // R6 alias wins over bank write
    step("R6", 1, 1, 2, 2'b11, 16'h0000, 0, 0, 0, 1, 6'd35, 1, '1);
    rd("R6 alias priority", 2, 2'b11);
    // R7 bit op wins over bank write
    step("R7", 1, 1, 1, 2'b11, 16'hFFFF, 2'd2, 6'd17, 0, 0, 0, 0, '1);
    rd("R7 bit priority", 1, 2'b11);
    // R8 partial last word
    step("R8", 1, 1, 3, 2'b11, 16'h0000, 0, 0, 0, 0, 0, 0, '1);
    rd("R8 fixed ones", 3, 2'b11);
    step("R8", 0, 0, 0, 0, 0, 2'd2, 6'd57, 0, 1, 6'd60, 0, '1);
    rd("R8 ignored writes", 3, 2'b11);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'd61, 0, '1);
    // R5 alias write then bank read
    step("R5", 0, 0, 0, 0, 0, 0, 0, 0, 1, 6'd50, 0, '1);
    rd("R5 alias visible", 3, 2'b11);
    idle();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic rq, we, bv, swe, sv;
      logic [1:0] wi, be, op;
      logic [5:0] sel, sidx;
      rq = 1'($urandom); we = 1'($urandom); wi = 2'($urandom); be = 2'($urandom);
      op = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      sel = 6'($urandom); bv = 1'($urandom);
      swe = ($urandom % 4 == 0); sidx = 6'($urandom); sv = 1'($urandom);
      step("R10 random read", rq, we, wi, be, 16'($urandom), op, sel, bv, swe, sidx, sv,
           {20'($urandom), 32'($urandom)});
    end
    idle();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule